// File: doc/BRIEF.md
# Engine Reset Handshake Controller

This block holds the reset handshake state for one execution engine and the reset bits for a set of hardware domains. Software reaches it through a plain register write port. A write to the engine control register is masked: bits 31:16 choose which of bits 15:0 are allowed to change. Software asks the engine to stop by setting the request bit. It then waits for the engine to report that it is ready to be reset. If the engine has raised a catastrophic error, software writes that error bit back to start recovery. Hardware clears the bit on its own when the engine reports that recovery is done, and the ready handshake is not used in that case.

A second register takes a mask of domains to reset. Each selected domain sees its reset output asserted until it acknowledges, and its bit then clears itself. Software can read the register back as completion status. The full-reset bit drives reset into every domain at once. It stays set until each domain has acknowledged at least once. A cycle counter watches any handshake that is still pending and raises a sticky timeout flag. Any later register write clears that flag.

The block has no streaming data path, so every pin is a plain level with no back-pressure. All state is held in registers, and each effect is visible one clock after the edge that causes it.

Top module: `eng_rst_ctrl`

## Requirements
- R1: On a control write (`wr_sel`=0), bit 0 (request) updates from data bit 0 only when enable bit 16 is set. Bits 1 (ready) and 2 (catastrophic error) can never be written to a value directly, whatever the enable bits say.
- R2: `ctl_rd` reports request in bit 0, ready in bit 1 and catastrophic error in bit 2. Ready is high one cycle after the request bit and `eng_quiesced` were both high, and low one cycle after either of them was low.
- R3: Clearing the request bit with a masked write cancels a pending reset. The request bit drops after the write edge and ready drops one cycle later.
- R4: `eng_cat_raise` sets the error bit. Writing 1 to bit 2 with enable bit 18 set, while the error bit is set, raises `eng_recover` whatever the state of ready. A cycle with `eng_recover_done` high then clears both the error bit and `eng_recover`. The same write while no error is flagged has no effect.
- R5: A handshake is pending while the request bit is set without ready, or while recovery runs. After `TIMEOUT_CYC` pending cycles, `timeout_err` sets. It stays set after the handshake ends, and any register write clears it.
- R6: In the domain register (`wr_sel`=1), bit 0 is full reset, bit 1 render, bit 2 media, bit 3 blitter, bit 4 video enhancement, bit 5 microcontroller and bit 7 second media. A write ORs these bits into the pending set. Bit 6 and bits 31:8 are ignored.
- R7: A pending per-domain bit drives `dom_rst` at that bit position. It clears itself at the edge where its `dom_ack` bit is high, and `dom_rd` shows the pending set.
- R8: While full reset is pending, `dom_rst` drives every domain (mask 0xBE). Bit 0 clears only after acknowledgements from all six domains have arrived, in any cycles and in any order.
- R9: Under reset, every output reads zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 1 | 0 = engine control register, 1 = domain register |
| wr_data | input | 32 | Write data; for control, 31:16 are bit enables |
| eng_quiesced | input | 1 | Engine has stopped and may be reset |
| eng_cat_raise | input | 1 | Engine reports a catastrophic error |
| eng_recover_done | input | 1 | Engine finished catastrophic recovery |
| dom_ack | input | 8 | Per-domain reset acknowledge |
| ctl_rd | output | 16 | Control register read value |
| dom_rd | output | 8 | Domain register read value (pending bits) |
| timeout_err | output | 1 | Sticky handshake timeout flag |
| eng_stop_req | output | 1 | Request to the engine to quiesce |
| eng_recover | output | 1 | Catastrophic recovery in progress |
| dom_rst | output | 8 | Reset drive to each domain |

## Verification
The bench targets masked writes whose enable bits are clear. A design that ignored the enable bits would let request toggle, or would let software set ready or the error bit. Cancellation is checked cycle by cycle, so a ready that lingers or drops too early shows up at once. Full reset gets acknowledgements spread over several cycles. A design that cleared bit 0 on the first acknowledgement, or one that still needed all acks in a single cycle, would drop or stall the bit. The timeout is checked at its exact cycle and again after the handshake ends. A flag that is not sticky, fires a cycle off, or survives a write is flagged. So is a recovery write made with no error present.

// File: rtl/rst_hs_pkg.sv
package rst_hs_pkg;
  localparam int CTL_REQ = 0;
  localparam int CTL_RDY = 1;
  localparam int CTL_CAT = 2;
  localparam int CTL_W   = 16;
  localparam int DOM_W   = 8;
  localparam int DOM_FULL = 0;
  localparam logic [DOM_W-1:0] DOM_PHYS  = 8'b1011_1110;
  localparam logic [DOM_W-1:0] DOM_VALID = 8'b1011_1111;
endpackage

// File: rtl/rst_hs_engine.sv
module rst_hs_engine
  import rst_hs_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic ctl_wr,
  input  logic [31:0] wdata,
  input  logic quiesced,
  input  logic cat_raise,
  input  logic recover_done,
  output logic req_q,
  output logic rdy_q,
  output logic cat_q,
  output logic rec_q,
  output logic pending
);
  logic req_we, rec_start;

  assign req_we    = ctl_wr && wdata[CTL_W + CTL_REQ];
  assign rec_start = ctl_wr && wdata[CTL_W + CTL_CAT] && wdata[CTL_CAT] && cat_q && !rec_q;
  assign pending   = (req_q && !rdy_q) || rec_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      req_q <= 1'b0;
      rdy_q <= 1'b0;
    end else begin
      if (req_we) req_q <= wdata[CTL_REQ];
      rdy_q <= req_q && quiesced;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cat_q <= 1'b0;
      rec_q <= 1'b0;
    end else begin
      if (rec_q && recover_done) begin
        cat_q <= 1'b0;
        rec_q <= 1'b0;
      end
      if (rec_start) rec_q <= 1'b1;
      if (cat_raise) cat_q <= 1'b1;
    end
  end

  // R1
  req_masked_chk: assert property (@(posedge clk) disable iff (rst)
    (ctl_wr && !wdata[CTL_W + CTL_REQ]) |=> $stable(req_q));
  // R4
  rec_needs_cat_chk: assert property (@(posedge clk) disable iff (rst)
    rec_q |-> cat_q);
  // R4
  cat_clear_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(cat_q) |-> $past(recover_done && rec_q));
endmodule

// File: rtl/rst_hs_timer.sv
module rst_hs_timer #(
  parameter int TIMEOUT_CYC = 87500
) (
  input  logic clk,
  input  logic rst,
  input  logic pending,
  input  logic clr,
  output logic err_q
);
  localparam int CW = $clog2(TIMEOUT_CYC + 1);
  localparam logic [CW-1:0] LAST = CW'(TIMEOUT_CYC - 1);

  logic [CW-1:0] cnt_q;
  logic hit;

  assign hit = pending && (cnt_q == LAST);

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
      err_q <= 1'b0;
    end else begin
      if (!pending) cnt_q <= '0;
      else if (cnt_q != LAST) cnt_q <= cnt_q + 1'b1;
      if (clr) err_q <= 1'b0;
      if (hit) err_q <= 1'b1;
    end
  end

  // R5
  err_cause_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(err_q) |-> $past(pending));
  // R5
  err_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(err_q) |-> $past(clr));
endmodule

// File: rtl/rst_hs_domains.sv
module rst_hs_domains
  import rst_hs_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic dom_wr,
  input  logic [DOM_W-1:0] wmask,
  input  logic [DOM_W-1:0] ack,
  output logic [DOM_W-1:0] pend_q,
  output logic [DOM_W-1:0] rst_out
);
  logic [DOM_W-1:0] seen_q, seen_all, set_v;
  logic full_done;

  assign set_v     = dom_wr ? (wmask & DOM_VALID) : '0;
  assign seen_all  = (seen_q | ack) & DOM_PHYS;
  assign full_done = pend_q[DOM_FULL] && (seen_all == DOM_PHYS);

  generate
    for (genvar i = 0; i < DOM_W; i++) begin : g_dom
      if (DOM_PHYS[i]) begin : g_phys
        always_ff @(posedge clk) begin
          if (rst) begin
            pend_q[i] <= 1'b0;
            seen_q[i] <= 1'b0;
          end else begin
            if (pend_q[i] && ack[i]) pend_q[i] <= 1'b0;
            if (set_v[i]) pend_q[i] <= 1'b1;
            if (full_done) seen_q[i] <= 1'b0;
            else if (pend_q[DOM_FULL] && ack[i]) seen_q[i] <= 1'b1;
          end
        end
        assign rst_out[i] = pend_q[i] || pend_q[DOM_FULL];

        // R7
        self_clear_chk: assert property (@(posedge clk) disable iff (rst)
          $fell(pend_q[i]) |-> $past(ack[i]));
      end else if (i == DOM_FULL) begin : g_full
        always_ff @(posedge clk) begin
          if (rst) pend_q[i] <= 1'b0;
          else begin
            if (full_done) pend_q[i] <= 1'b0;
            if (set_v[i]) pend_q[i] <= 1'b1;
          end
        end
        assign seen_q[i]  = 1'b0;
        assign rst_out[i] = 1'b0;
      end else begin : g_none
        assign pend_q[i]  = 1'b0;
        assign seen_q[i]  = 1'b0;
        assign rst_out[i] = 1'b0;
      end
    end
  endgenerate

  // R8
  full_clear_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(pend_q[DOM_FULL]) |-> $past(((seen_q | ack) & DOM_PHYS) == DOM_PHYS));
  // R8
  full_drive_chk: assert property (@(posedge clk) disable iff (rst)
    pend_q[DOM_FULL] |-> ((rst_out & DOM_PHYS) == DOM_PHYS));
endmodule

// File: rtl/eng_rst_ctrl.sv
module eng_rst_ctrl
  import rst_hs_pkg::*;
#(
  parameter int TIMEOUT_CYC = 87500
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        wr_en,
  input  logic        wr_sel,
  input  logic [31:0] wr_data,
  input  logic        eng_quiesced,
  input  logic        eng_cat_raise,
  input  logic        eng_recover_done,
  input  logic [7:0]  dom_ack,
  output logic [15:0] ctl_rd,
  output logic [7:0]  dom_rd,
  output logic        timeout_err,
  output logic        eng_stop_req,
  output logic        eng_recover,
  output logic [7:0]  dom_rst
);
  logic req, rdy, cat, rec, pend;

  rst_hs_engine u_eng (
    .clk(clk), .rst(rst),
    .ctl_wr(wr_en && !wr_sel), .wdata(wr_data),
    .quiesced(eng_quiesced), .cat_raise(eng_cat_raise),
    .recover_done(eng_recover_done),
    .req_q(req), .rdy_q(rdy), .cat_q(cat), .rec_q(rec), .pending(pend)
  );

  rst_hs_timer #(.TIMEOUT_CYC(TIMEOUT_CYC)) u_tmr (
    .clk(clk), .rst(rst), .pending(pend), .clr(wr_en), .err_q(timeout_err)
  );

  rst_hs_domains u_dom (
    .clk(clk), .rst(rst),
    .dom_wr(wr_en && wr_sel), .wmask(wr_data[DOM_W-1:0]),
    .ack(dom_ack), .pend_q(dom_rd), .rst_out(dom_rst)
  );

  always_comb begin
    ctl_rd = '0;
    ctl_rd[CTL_REQ] = req;
    ctl_rd[CTL_RDY] = rdy;
    ctl_rd[CTL_CAT] = cat;
  end

  assign eng_stop_req = req;
  assign eng_recover  = rec;

  // R2
  rdy_follows_chk: assert property (@(posedge clk) disable iff (rst)
    (!eng_stop_req || !eng_quiesced) |=> !ctl_rd[CTL_RDY]);
endmodule

// File: tb/tb_eng_rst_ctrl.sv
module tb_eng_rst_ctrl;
  localparam int T = 20;
  logic clk = 0, rst = 1;
  logic wr_en = 0, wr_sel = 0;
  logic [31:0] wr_data = 0;
  logic eng_quiesced = 0, eng_cat_raise = 0, eng_recover_done = 0;
  logic [7:0] dom_ack = 0;
  logic [15:0] ctl_rd;
  logic [7:0] dom_rd, dom_rst;
  logic timeout_err, eng_stop_req, eng_recover;
  int total = 0, bad = 0;
  bit finished = 0;

  always #4 clk = ~clk;

  eng_rst_ctrl #(.TIMEOUT_CYC(T)) dut (.*);

  // behavioural reference
  bit m_req, m_rdy, m_cat, m_rec, m_err;
  int m_cnt;
  bit [7:0] m_dom, m_seen;
  localparam bit [7:0] PHYS = 8'hBE;

  always @(posedge clk) begin
    bit n_req, n_rdy, n_cat, n_rec, n_err, pendh;
    int n_cnt;
    bit [7:0] n_dom, n_seen;
    if (rst) begin
      m_req = 0; m_rdy = 0; m_cat = 0; m_rec = 0; m_err = 0; m_cnt = 0;
      m_dom = 0; m_seen = 0;
    end else begin
      n_req = m_req;
      if (wr_en && !wr_sel && wr_data[16]) n_req = wr_data[0];
      n_rdy = m_req && eng_quiesced;
      n_cat = m_cat; n_rec = m_rec;
      if (m_rec && eng_recover_done) begin n_cat = 0; n_rec = 0; end
      if (wr_en && !wr_sel && wr_data[18] && wr_data[2] && m_cat && !m_rec) n_rec = 1;
      if (eng_cat_raise) n_cat = 1;
      pendh = (m_req && !m_rdy) || m_rec;
      n_cnt = !pendh ? 0 : (m_cnt < T-1 ? m_cnt + 1 : m_cnt);
      n_err = m_err;
      if (wr_en) n_err = 0;
      if (pendh && m_cnt == T-1) n_err = 1;
      n_dom = m_dom & ~(dom_ack & PHYS);
      n_seen = m_seen;
      if (m_dom[0]) begin
        if (((m_seen | dom_ack) & PHYS) == PHYS) begin
          n_dom[0] = 0; n_seen = 0;
        end else n_seen = (m_seen | dom_ack) & PHYS;
      end
      if (wr_en && wr_sel) n_dom = n_dom | (wr_data[7:0] & 8'hBF);
      m_req = n_req; m_rdy = n_rdy; m_cat = n_cat; m_rec = n_rec;
      m_cnt = n_cnt; m_err = n_err; m_dom = n_dom; m_seen = n_seen;
    end
  end

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h t=%0t", tag, act, exp, $time);
    end
  endtask

  // per-cycle comparison, 2 ns after each rising edge
  always @(posedge clk) begin
    #2;
    if (!finished) begin
      chk("R2", ctl_rd, {13'b0, m_cat, m_rdy, m_req});
      chk("R5", timeout_err, m_err);
      chk("R4", eng_recover, m_rec);
      chk("R7", dom_rd, m_dom);
      chk("R8", dom_rst, m_dom[0] ? (m_dom | PHYS) & PHYS : m_dom & PHYS);
    end
  end

  task automatic wr(bit sel, logic [31:0] d);
    @(negedge clk); wr_en = 1; wr_sel = sel; wr_data = d;
    @(negedge clk); wr_en = 0; wr_data = 0;
  endtask

  task automatic ack(logic [7:0] v);
    @(negedge clk); dom_ack = v;
    @(negedge clk); dom_ack = 0;
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    #(8 * 200000);
    total++; bad++;
    $display("FAIL watchdog act=running exp=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    idle(3);
    // R9 reset state
    chk("R9", {ctl_rd, dom_rd, dom_rst}, 0);
    chk("R9", {timeout_err, eng_stop_req, eng_recover}, 0);
    rst = 0;
    idle(2);
    // R2 request then ready
    wr(0, 32'h0001_0001);
    chk("R2", ctl_rd, 16'h0001);
    chk("R2", eng_stop_req, 1);
    eng_quiesced = 1;
    idle(1);
    chk("R2", ctl_rd, 16'h0003);
    // R1 masked-off / read-only bits
    wr(0, 32'h0006_0006);
    chk("R1", ctl_rd, 16'h0003);
    wr(0, 32'h0000_0000);
    chk("R1", ctl_rd, 16'h0003);
    // R3 cancel
    wr(0, 32'h0001_0000);
    chk("R3", ctl_rd, 16'h0002);
    idle(1);
    chk("R3", ctl_rd, 16'h0000);
    // R5 timeout
    eng_quiesced = 0;
    wr(0, 32'h0001_0001);
    idle(T - 2);
    chk("R5", timeout_err, 0);
    idle(2);
    chk("R5", timeout_err, 1);
    eng_quiesced = 1;
    idle(4);
    chk("R5", timeout_err, 1);
    wr(0, 32'h0001_0000);
    chk("R5", timeout_err, 0);
    idle(2);
    // R4 recovery write without error has no effect
    wr(0, 32'h0004_0004);
    chk("R4", eng_recover, 0);
    @(negedge clk); eng_cat_raise = 1;
    @(negedge clk); eng_cat_raise = 0;
    chk("R4", ctl_rd, 16'h0004);
    wr(0, 32'h0004_0004);
    chk("R4", eng_recover, 1);
    idle(3);
    @(negedge clk); eng_recover_done = 1;
    @(negedge clk); eng_recover_done = 0;
    chk("R4", ctl_rd, 16'h0000);
    chk("R4", eng_recover, 0);
    // R7 per-domain self-clear
    wr(1, 32'h0000_000A);
    chk("R7", dom_rst, 8'h0A);
    ack(8'h02);
    chk("R7", dom_rd, 8'h08);
    ack(8'h08);
    chk("R7", dom_rd, 8'h00);
    // R6 ignored bits and bit 7
    wr(1, 32'h0000_FF40);
    chk("R6", dom_rd, 8'h00);
    wr(1, 32'h0000_0080);
    chk("R6", dom_rst, 8'h80);
    ack(8'h80);
    // R8 full reset with staggered acks
    wr(1, 32'h0000_0001);
    chk("R8", dom_rst, 8'hBE);
    ack(8'h02); ack(8'h24); idle(2); ack(8'h08); ack(8'h10);
    chk("R8", dom_rd, 8'h01);
    chk("R8", dom_rst, 8'hBE);
    ack(8'h80);
    chk("R8", dom_rd, 8'h00);
    chk("R8", dom_rst, 8'h00);
    idle(3);
    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule